// File: doc/BRIEF.md
# Burst Function-Control Sequencer

This block sits between a controller's command pins and a synchronous, pipelined memory core. On each rising clock edge it samples three active-low control inputs and decodes them into one of three commands. A load captures a new base address, a direction and a data rate. A continue-burst advances the current four-beat burst. A no-operation leaves the data bus undriven. The decoded command, the read and write strobes, the beat-count flag, the high-Z flag and the addresses of the beats are registered. They are presented in the cycle that follows the command cycle.

The block keeps the burst start offset, the beat position and the upper address bits that belong to the most recent load. It also keeps the direction and data rate last used, so that a continue-burst reuses them. In double-rate mode a command carries two beat addresses: the second is the next address in the burst order. In single-rate mode it carries one. The two low address bits follow either a counting order or an exclusive-or order. The order is chosen by an input that is captured at each load.

Top module: `bfc_sequencer`

## Requirements
- R1: With `fc_load_n` low at a rising edge, the next cycle shows `cmd_o` = 1 (load). `wr_stb` is high if `fc_write_n` was low, otherwise `rd_stb` is high. `ddr_beat` is high if `fc_single` was low.
- R2: With `fc_load_n` and `fc_write_n` both high after a load or an honoured continue, the next cycle shows `cmd_o` = 2 (continue) with the same strobe direction as before. The value of `fc_single` has no effect.
- R3: With `fc_load_n` high and `fc_write_n` low, the next cycle shows `cmd_o` = 0, both strobes low, `ddr_beat` low and `bus_hiz` high.
- R4: A continue request right after reset, or right after a no-operation, is turned into a no-operation with `bus_hiz` high in the next cycle.
- R5: With the order captured low at the load, beat k of the burst has low bits (start + k) mod 4.
- R6: With the order captured high at the load, beat k of the burst has low bits start XOR k.
- R7: In double-rate mode `beat1_addr` is the next address of the burst after `beat0_addr`, and it has the same upper bits.
- R8: In single-rate mode `ddr_beat` is low and `beat1_addr` equals `beat0_addr`.
- R9: A continue advances the beat position by two in double-rate mode and by one in single-rate mode. The position wraps inside the four-address group, and the upper address bits are kept from the load.
- R10: The data rate changes only at a load. A continue keeps the rate latched at the last load.
- R11: While reset is applied, and until the first command after it, `cmd_o` = 0, the strobes and `ddr_beat` are low and `bus_hiz` is high.
- R12: The burst order input is captured at a load. Changes to it during continue cycles do not alter the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fc_load_n | input | 1 | Low: load a new base address |
| fc_write_n | input | 1 | At a load, low selects write. Otherwise, low requests a no-operation |
| fc_single | input | 1 | At a load, high selects single rate and low selects double rate |
| order_ilv | input | 1 | Burst order captured at a load: 1 exclusive-or, 0 counting |
| base_addr | input | ADDR_W | Base address captured at a load |
| cmd_o | output | 2 | Registered command: 0 no-op, 1 load, 2 continue |
| rd_stb | output | 1 | Read beat(s) in this cycle |
| wr_stb | output | 1 | Write beat(s) in this cycle |
| ddr_beat | output | 1 | Two beats in this cycle (rising and falling half) |
| bus_hiz | output | 1 | Data bus left undriven in this cycle |
| beat0_addr | output | ADDR_W | Address of the first beat |
| beat1_addr | output | ADDR_W | Address of the second beat; equals `beat0_addr` in single rate |

## Verification
Three things can land in one edge: a continue request, the advance of the burst position and a request to change the rate or the order. A continue that arrives with `fc_single` or `order_ilv` toggled must advance the position using the latched rate and order, not the new pin values. A second collision is a continue arriving one cycle after a no-operation. In that cycle the strobe decision and the high-Z decision are both taken from the previous command. Directed sequences force both cases. Seeded random traffic, with frequent loads and toggled pins, then mixes them further. Every registered output is compared against a bench model that keeps its own burst position.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_CONT = 2'd2
  } bfc_cmd_e;

  // low two bits of a burst beat from start offset and beat index
  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                          input logic [1:0] idx,
                                          input logic       ilv);
    beat_lsb = ilv ? (start ^ idx) : 2'(start + idx);
  endfunction

endpackage

// File: rtl/bfc_decode.sv
module bfc_decode
  import bfc_pkg::*;
(
  input  logic     load_n,
  input  logic     write_n,
  input  logic     single,
  input  logic     prev_act,
  input  logic     prev_wr,
  input  logic     prev_ddr,
  output bfc_cmd_e cmd,
  output logic     eff_wr,
  output logic     eff_ddr,
  output logic     act
);

  always_comb begin
    if (!load_n) begin
      cmd     = CMD_LOAD;
      eff_wr  = ~write_n;
      eff_ddr = ~single;
    end else if (write_n && prev_act) begin
      // continue: direction and rate come from the previous command
      cmd     = CMD_CONT;
      eff_wr  = prev_wr;
      eff_ddr = prev_ddr;
    end else begin
      // plain no-op, or continue with nothing to continue
      cmd     = CMD_NOP;
      eff_wr  = prev_wr;
      eff_ddr = prev_ddr;
    end
    act = (cmd != CMD_NOP);
  end

endmodule

// File: rtl/bfc_burst.sv
module bfc_burst
  import bfc_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bfc_cmd_e          cmd,
  input  logic              ddr,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              order_in,
  output logic [ADDR_W-1:0] beat_a,
  output logic [ADDR_W-1:0] beat_b
);

  localparam int UP_W = ADDR_W - 2;
  localparam int NBEAT = 2;

  logic [1:0]      start_q, start_n;
  logic [1:0]      idx_q, idx_n;
  logic [UP_W-1:0] up_q, up_n;
  logic            ilv_q, ilv_n;
  logic            upd;

  always_comb begin
    start_n = start_q;
    idx_n   = idx_q;
    up_n    = up_q;
    ilv_n   = ilv_q;
    upd     = 1'b0;
    unique case (cmd)
      CMD_LOAD: begin
        start_n = base_addr[1:0];
        idx_n   = 2'd0;
        up_n    = base_addr[ADDR_W-1:2];
        ilv_n   = order_in;
        upd     = 1'b1;
      end
      CMD_CONT: begin
        idx_n = 2'(idx_q + (ddr ? 2'd2 : 2'd1));
        upd   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      idx_q   <= '0;
      up_q    <= '0;
      ilv_q   <= 1'b0;
    end else if (upd) begin
      start_q <= start_n;
      idx_q   <= idx_n;
      up_q    <= up_n;
      ilv_q   <= ilv_n;
    end
  end

  logic [ADDR_W-1:0] beat [NBEAT];

  for (genvar g = 0; g < NBEAT; g++) begin : g_beat
    assign beat[g] = {up_n, beat_lsb(start_n, 2'(idx_n + 2'(g)), ilv_n)};
  end

  assign beat_a = beat[0];
  assign beat_b = beat[1];

  assert_load_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOAD) |=> (idx_q == 2'd0));

endmodule

// File: rtl/bfc_outreg.sv
module bfc_outreg
  import bfc_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bfc_cmd_e          cmd,
  input  logic              eff_wr,
  input  logic              eff_ddr,
  input  logic [ADDR_W-1:0] beat_a,
  input  logic [ADDR_W-1:0] beat_b,
  output bfc_cmd_e          cmd_q,
  output logic              rd_q,
  output logic              wr_q,
  output logic              ddr_q,
  output logic              hiz_q,
  output logic [ADDR_W-1:0] a0_q,
  output logic [ADDR_W-1:0] a1_q
);

  logic              act;
  logic              rd_n, wr_n, ddr_n, hiz_n;
  logic [ADDR_W-1:0] a0_n, a1_n;

  always_comb begin
    act   = (cmd != CMD_NOP);
    rd_n  = act & ~eff_wr;
    wr_n  = act &  eff_wr;
    ddr_n = act &  eff_ddr;
    hiz_n = ~act;
    a0_n  = beat_a;
    a1_n  = eff_ddr ? beat_b : beat_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_NOP;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      ddr_q <= 1'b0;
      hiz_q <= 1'b1;
    end else begin
      cmd_q <= cmd;
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      ddr_q <= ddr_n;
      hiz_q <= hiz_n;
    end
  end

  // addresses only move when a beat is scheduled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a0_q <= '0;
      a1_q <= '0;
    end else if (act) begin
      a0_q <= a0_n;
      a1_q <= a1_n;
    end
  end

  assert_one_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_q && wr_q));

  assert_cont_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_CONT) |-> ($past(cmd_q) != CMD_NOP));

  assert_cont_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_CONT) |-> (rd_q == $past(rd_q) && wr_q == $past(wr_q)));

  assert_rate_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_CONT) |-> (ddr_q == $past(ddr_q)));

  assert_upper_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_CONT) |-> (a0_q[ADDR_W-1:2] == $past(a0_q[ADDR_W-1:2])));

  assert_ddr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_CONT && ddr_q) |->
      (a0_q[1] != $past(a0_q[1]) && a0_q[0] == $past(a0_q[0])));

  assert_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_q |-> (a1_q[0] != a0_q[0] && a1_q[ADDR_W-1:2] == a0_q[ADDR_W-1:2]));

  assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_q || wr_q) && !ddr_q) |-> (a1_q == a0_q));

  assert_nop_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_NOP) |-> (hiz_q && !rd_q && !wr_q && !ddr_q));

endmodule

// File: rtl/bfc_sequencer.sv
module bfc_sequencer
  import bfc_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_load_n,
  input  logic              fc_write_n,
  input  logic              fc_single,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [1:0]        cmd_o,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              ddr_beat,
  output logic              bus_hiz,
  output logic [ADDR_W-1:0] beat0_addr,
  output logic [ADDR_W-1:0] beat1_addr
);

  localparam int SYNC_N = 2;

  // reset: asserted at once, released after SYNC_N edges
  logic [SYNC_N-1:0] rs_q;
  logic              rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_i_n = rs_q[SYNC_N-1];

  // previous-command latch
  logic act_q, wr_q, ddr_q;
  logic act_n, wr_n, ddr_n;

  bfc_cmd_e cmd;
  logic     eff_wr, eff_ddr, act;

  bfc_decode u_dec (
    .load_n   (fc_load_n),
    .write_n  (fc_write_n),
    .single   (fc_single),
    .prev_act (act_q),
    .prev_wr  (wr_q),
    .prev_ddr (ddr_q),
    .cmd      (cmd),
    .eff_wr   (eff_wr),
    .eff_ddr  (eff_ddr),
    .act      (act)
  );

  always_comb begin
    act_n = act;
    wr_n  = act ? eff_wr  : wr_q;
    ddr_n = act ? eff_ddr : ddr_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      ddr_q <= 1'b0;
    end else begin
      act_q <= act_n;
      wr_q  <= wr_n;
      ddr_q <= ddr_n;
    end
  end

  logic [ADDR_W-1:0] beat_a, beat_b;

  bfc_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cmd       (cmd),
    .ddr       (eff_ddr),
    .base_addr (base_addr),
    .order_in  (order_ilv),
    .beat_a    (beat_a),
    .beat_b    (beat_b)
  );

  bfc_cmd_e cmd_r;

  bfc_outreg #(.ADDR_W(ADDR_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .cmd     (cmd),
    .eff_wr  (eff_wr),
    .eff_ddr (eff_ddr),
    .beat_a  (beat_a),
    .beat_b  (beat_b),
    .cmd_q   (cmd_r),
    .rd_q    (rd_stb),
    .wr_q    (wr_stb),
    .ddr_q   (ddr_beat),
    .hiz_q   (bus_hiz),
    .a0_q    (beat0_addr),
    .a1_q    (beat1_addr)
  );

  assign cmd_o = cmd_r;

  assert_load_seen_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($past(rst_i_n) && !$past(fc_load_n)) |-> (cmd_o == 2'd1));

  assert_nop_req_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($past(rst_i_n) && $past(fc_load_n) && !$past(fc_write_n)) |-> bus_hiz);

endmodule

// File: tb/bfc_sequencer_test.sv
`timescale 1ns/1ps
module bfc_sequencer_test;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_n, wr_n, sg, ord;
  logic [AW-1:0] ad;
  logic [1:0]    cmd_o;
  logic          rd_stb, wr_stb, ddr_beat, bus_hiz;
  logic [AW-1:0] b0, b1;

  always #2 clk = ~clk;

  bfc_sequencer #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .fc_load_n(ld_n), .fc_write_n(wr_n),
    .fc_single(sg), .order_ilv(ord), .base_addr(ad), .cmd_o(cmd_o),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .ddr_beat(ddr_beat), .bus_hiz(bus_hiz),
    .beat0_addr(b0), .beat1_addr(b1)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit          mv, mw, md, mord;
  bit [1:0]    mstart, midx;
  bit [AW-3:0] mup;
  // expectation for next sampled cycle
  bit          have;
  bit [1:0]    e_cmd;
  bit          e_rd, e_wr, e_ddr, e_hiz;
  bit [AW-1:0] e_a0, e_a1;
  string       t_cmd, t_ddr, t_a0, t_a1, ovr;

  function automatic bit [1:0] lsb(bit [1:0] s, bit [1:0] i, bit o);
    int v;
    if (o) v = s ^ i;
    else   v = (s + i) % 4;
    return 2'(v);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(t_cmd, 32'(cmd_o), 32'(e_cmd));
    chk(t_cmd, 32'(rd_stb), 32'(e_rd));
    chk(t_cmd, 32'(wr_stb), 32'(e_wr));
    chk(t_ddr, 32'(ddr_beat), 32'(e_ddr));
    chk(e_cmd == 2'd0 ? t_cmd : "R3", 32'(bus_hiz), 32'(e_hiz));
    if (e_cmd != 2'd0) begin
      chk(t_a0, 32'(b0), 32'(e_a0));
      chk(t_a1, 32'(b1), 32'(e_a1));
    end
  endtask

  task automatic step(bit l, bit w, bit s, bit o, bit [AW-1:0] a);
    bit act;
    @(negedge clk);
    if (have) compare();
    if (!l) begin
      e_cmd = 2'd1; mv = 1; mw = !w; md = !s; mstart = a[1:0]; midx = 0;
      mup = a[AW-1:2]; mord = o; t_cmd = "R1";
    end else if (w && mv) begin
      e_cmd = 2'd2; midx = midx + (md ? 2'd2 : 2'd1); t_cmd = "R2";
    end else begin
      e_cmd = 2'd0; t_cmd = w ? "R4" : "R3"; mv = 0;
    end
    act   = (e_cmd != 2'd0);
    e_rd  = act && !mw;
    e_wr  = act && mw;
    e_ddr = act && md;
    e_hiz = !act;
    e_a0  = {mup, lsb(mstart, midx, mord)};
    e_a1  = md ? {mup, lsb(mstart, 2'(midx + 2'd1), mord)} : e_a0;
    t_ddr = (e_cmd == 2'd2) ? "R10" : (md ? "R7" : "R8");
    t_a0  = (ovr != "") ? ovr : (e_cmd == 2'd2) ? "R9" : (mord ? "R6" : "R5");
    t_a1  = (ovr != "") ? ovr : (md ? "R7" : "R8");
    ld_n = l; wr_n = w; sg = s; ord = o; ad = a;
    have = 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h1a2b3c4d);
    ovr = ""; have = 0; mv = 0; mw = 0; md = 0; mord = 0;
    mstart = 0; midx = 0; mup = 0;
    rst_n = 1'b0; ld_n = 1; wr_n = 0; sg = 0; ord = 0; ad = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", 32'(cmd_o), 0);
    chk("R11", 32'(bus_hiz), 1);
    chk("R11", 32'({rd_stb, wr_stb, ddr_beat}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", 32'(bus_hiz), 1);
    chk("R11", 32'(cmd_o), 0);

    // R4: continue straight after reset, then after a NOP
    step(1, 1, 0, 0, '0);
    step(1, 0, 0, 0, '0);
    step(1, 1, 0, 0, '0);
    // R5 + R9: linear DDR read from 01, wraps
    step(0, 1, 0, 0, 20'hABCD1);
    step(1, 1, 0, 0, '0);
    step(1, 1, 0, 0, '0);
    // R6 + R9: interleaved SDR write from 10
    step(0, 0, 1, 1, 20'h12342);
    step(1, 1, 1, 0, '0);
    step(1, 1, 1, 0, '0);
    step(1, 1, 1, 0, '0);
    step(1, 1, 1, 0, '0);
    // R10: rate pin toggled during continue (DDR latched)
    step(0, 0, 0, 1, 20'h00003);
    step(1, 1, 1, 1, '0);
    step(1, 1, 1, 0, '0);
    // R12: order pin toggled during continue (linear latched)
    ovr = "R12";
    step(0, 1, 1, 0, 20'hFFFF3);
    step(1, 1, 1, 1, '0);
    step(1, 1, 1, 1, '0);
    step(1, 1, 0, 1, '0);
    ovr = "";
    // NOP then continue then continue (R3, R4)
    step(1, 0, 1, 1, '0);
    step(1, 1, 1, 1, '0);
    step(1, 1, 0, 0, '0);

    for (int i = 0; i < 3000; i++) begin
      int unsigned p;
      bit l, w;
      p = $urandom % 100;
      l = (p >= 30);
      w = l ? ($urandom % 100 < 80) : $urandom[0];
      step(l, w, $urandom[0], $urandom[0], AW'($urandom));
    end
    step(1, 0, 0, 0, '0);
    step(1, 0, 0, 0, '0);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

endmodule